// File: doc/BRIEF.md
# Packed Vector Add-With-Carry Unit

This block adds two 128-bit vector register slices element by element. Each element also adds one carry-in bit, taken from a mask register. The element width is picked per operation as 8, 16, 32 or 64 bits. The 128-bit datapath is split into independent adders at every element boundary. The carry out of each element's top bit is dropped, and no carry mask is produced. Software that needs the carry-out for multi-word arithmetic must compute it with a separate operation.

The mask register does not enable or disable elements here. Every body element (index below the active vector length) is written, whatever its mask bit holds. Tail elements keep the old destination value, which arrives on its own input. The operation exists only in the encoding with the mask-select bit clear. The other encoding, and any element-width code outside the four supported ones, raise an illegal flag and return the old destination unchanged.

The result and the illegal flag are registered. They appear one cycle after an accepted input, together with a one-cycle output valid pulse. They hold their value until the next accepted input.

Top module: `vcarry_add_unit`

## Requirements
- R1: For each body element i, `result` element i equals (src2[i] + src1[i] + carry bit), truncated to the element width. The carry out of the element's top bit is discarded.
- R2: A carry never crosses from one element into the next, even when an element wraps from all ones to zero.
- R3: `sew_sel` codes 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit elements. Element i occupies bits [i*W +: W] of every data bus.
- R4: Bit i of `carry_mask` (LSB first) is the carry-in of element i. Only the lowest 128/W mask bits are used, and higher mask bits have no effect on the result.
- R5: Every body element is written whatever its mask bit holds. A mask bit of 0 or 1 only changes the sum by 0 or 1.
- R6: Elements with index greater than or equal to `vl` take the matching bits of `old_dst`. A `vl` above the element count makes every element a body element.
- R7: When `vl` is 0 in a legal encoding, `result` equals `old_dst` and `illegal` is 0.
- R8: When `vm_bit` is 1, `illegal` is 1 and `result` equals `old_dst`.
- R9: When `sew_sel` is 4 to 7, `illegal` is 1 and `result` equals `old_dst`.
- R10: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, and low otherwise. `result` and `illegal` hold their value while no input is accepted.
- R11: After reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Accept the operands this cycle |
| src1 | input | 128 | First addend vector |
| src2 | input | 128 | Second addend vector |
| carry_mask | input | 16 | Per-element carry-in bits, LSB is element 0 |
| old_dst | input | 128 | Previous destination value, used for tail elements and rejected operations |
| sew_sel | input | 3 | Element width code: 0=8, 1=16, 2=32, 3=64, others illegal |
| vm_bit | input | 1 | Mask-select encoding bit; must be 0 |
| vl | input | 5 | Active vector length in elements |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 128 | Registered destination value |
| illegal | output | 1 | Registered reserved-encoding flag |

## Verification
The bench sets an element to all ones with a carry-in of 1 and checks that it wraps to zero. A design that let the carry leak across the element boundary would corrupt the neighbouring element. The bench sets mask bits above the element count at wide widths, which catches a design that indexes the mask by byte rather than by element. It also clears the mask bits of body elements and checks that the sum is still written, which catches a design that treats the mask as an element enable. Further corner cases are `vl` of zero, partial `vl` and `vl` beyond the element count, `vm_bit` set, and unsupported width codes. A design that got these wrong would merge the wrong bytes from `old_dst` or flag the wrong operations as illegal.

// File: rtl/vca_pkg.sv
package vca_pkg;

    typedef enum logic [2:0] {
        SEW_E8  = 3'd0,
        SEW_E16 = 3'd1,
        SEW_E32 = 3'd2,
        SEW_E64 = 3'd3
    } sew_code_e;

    function automatic logic sew_supported(input logic [2:0] code);
        return (code <= 3'd3);
    endfunction

endpackage

// File: rtl/vca_lane_ctrl.sv
module vca_lane_ctrl #(
    parameter int VLEN = 128,
    localparam int NB  = VLEN / 8,
    localparam int VLW = $clog2(NB + 1)
) (
    input  logic [1:0]     sew_code,
    input  logic [VLW-1:0] vl,
    input  logic [NB-1:0]  carry_mask,
    output logic [NB-1:0]  seg_start,
    output logic [NB-1:0]  seg_cin,
    output logic [NB-1:0]  seg_body
);
    // Per byte: does an element start here, which carry bit belongs to its
    // element, and is its element inside the active length.
    always_comb begin
        for (int j = 0; j < NB; j++) begin
            int span;
            int elem;
            span = 1 << int'(sew_code);
            elem = j / span;
            seg_start[j] = ((j % span) == 0);
            seg_cin[j]   = carry_mask[elem];
            seg_body[j]  = (elem < int'(vl));
        end
    end

    // R3: the number of element starts matches the selected width
    always_comb begin
        if (!$isunknown(sew_code)) begin
            a_r3_seg_count: assert ($countones(seg_start) == (NB >> int'(sew_code)));
        end
    end

endmodule

// File: rtl/vca_seg_adder.sv
module vca_seg_adder #(
    parameter int NB = 16,
    localparam int W = NB * 8
) (
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [NB-1:0] seg_start,
    input  logic [NB-1:0] seg_cin,
    output logic [W-1:0]  sum
);
    logic [NB-1:0] cin_eff;

    // Byte-sliced ripple adder, broken at every element start; the
    // element's carry bit is injected at the break.
    for (genvar j = 0; j < NB; j++) begin : g_byte
        if (j == 0) begin : g_first
            assign cin_eff[j] = seg_start[j] ? seg_cin[j] : 1'b0;
        end else begin : g_rest
            assign cin_eff[j] = seg_start[j] ? seg_cin[j] : g_byte[j-1].co;
        end

        if (j == NB - 1) begin : g_top
            assign sum[8*j +: 8] = opa[8*j +: 8] + opb[8*j +: 8] + {7'd0, cin_eff[j]};
        end else begin : g_mid
            logic [8:0] s9;
            assign s9 = {1'b0, opa[8*j +: 8]} + {1'b0, opb[8*j +: 8]} + {8'd0, cin_eff[j]};
            assign sum[8*j +: 8] = s9[7:0];
        end

        logic co;
        if (j == NB - 1) begin : g_nco
            assign co = 1'b0;
        end else begin : g_co
            assign co = g_mid.s9[8];
        end
    end

endmodule

// File: rtl/vcarry_add_unit.sv
module vcarry_add_unit #(
    parameter int VLEN = 128,
    localparam int NB  = VLEN / 8,
    localparam int VLW = $clog2(NB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [VLEN-1:0] src1,
    input  logic [VLEN-1:0] src2,
    input  logic [NB-1:0]   carry_mask,
    input  logic [VLEN-1:0] old_dst,
    input  logic [2:0]      sew_sel,
    input  logic            vm_bit,
    input  logic [VLW-1:0]  vl,
    output logic            out_valid,
    output logic [VLEN-1:0] result,
    output logic            illegal
);
    import vca_pkg::*;

    typedef struct packed {
        logic            vld;
        logic            ill;
        logic [VLEN-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [NB-1:0]   seg_start, seg_cin, seg_body;
    logic [VLEN-1:0] sum_w;
    logic            legal_w;

    vca_lane_ctrl #(.VLEN(VLEN)) u_ctrl (
        .sew_code   (sew_sel[1:0]),
        .vl         (vl),
        .carry_mask (carry_mask),
        .seg_start  (seg_start),
        .seg_cin    (seg_cin),
        .seg_body   (seg_body)
    );

    vca_seg_adder #(.NB(NB)) u_add (
        .opa       (src2),
        .opb       (src1),
        .seg_start (seg_start),
        .seg_cin   (seg_cin),
        .sum       (sum_w)
    );

    assign legal_w = !vm_bit && sew_supported(sew_sel);

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ill = !legal_w;
            for (int j = 0; j < NB; j++) begin
                st_d.res[8*j +: 8] = (legal_w && seg_body[j]) ? sum_w[8*j +: 8]
                                                              : old_dst[8*j +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign illegal   = st_q.ill;

    // R10
    a_r10_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    // R8
    a_r8_vm_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vm_bit) |=> (illegal && result == $past(old_dst)));
    // R9
    a_r9_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sew_sel > 3'd3) |=> (illegal && result == $past(old_dst)));
    // R7
    a_r7_vl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vl == '0 && !vm_bit && sew_sel <= 3'd3)
        |=> (!illegal && result == $past(old_dst)));

endmodule

// File: tb/vcarry_add_unit_test.sv
`timescale 1ns/1ps
module vcarry_add_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src1 = '0, src2 = '0, old_dst = '0;
    logic [15:0]  carry_mask = '0;
    logic [2:0]   sew_sel = '0;
    logic         vm_bit = 1'b0;
    logic [4:0]   vl = '0;
    logic         out_valid, illegal;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vcarry_add_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src1(src1), .src2(src2), .carry_mask(carry_mask), .old_dst(old_dst),
        .sew_sel(sew_sel), .vm_bit(vm_bit), .vl(vl),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    function automatic logic [128:0] ref_model(
        input logic [127:0] a, input logic [127:0] b, input logic [15:0] m,
        input logic [127:0] old, input logic [2:0] sel, input logic vmb,
        input logic [4:0] vlen);
        logic [127:0] res, em, ea, eb, s;
        int sw, n;
        if (vmb || sel > 3'd3) return {1'b1, old};
        sw  = 8 << int'(sel);
        n   = 128 / sw;
        em  = (128'd1 << sw) - 128'd1;
        res = old;
        for (int e = 0; e < n; e++) begin
            if (e < int'(vlen)) begin
                ea  = (a >> (e * sw)) & em;
                eb  = (b >> (e * sw)) & em;
                s   = (ea + eb + {127'd0, m[e]}) & em;
                res = (res & ~(em << (e * sw))) | (s << (e * sw));
            end
        end
        return {1'b0, res};
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [128:0] act, input logic [128:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [127:0] a, input logic [127:0] b,
                          input logic [15:0] m, input logic [127:0] old,
                          input logic [2:0] sel, input logic vmb,
                          input logic [4:0] vlen, input string tag);
        logic [128:0] exp;
        exp = ref_model(a, b, m, old, sel, vmb, vlen);
        @(negedge clk);
        src1 = a; src2 = b; carry_mask = m; old_dst = old;
        sew_sel = sel; vm_bit = vmb; vl = vlen; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1 && result === exp[127:0] && illegal === exp[128],
              tag, {illegal, result}, exp);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_valid === 1'b0 && illegal === 1'b0 && result === '0,
              "R11 reset", {illegal, result}, '0);
        rst_n = 1'b1;

        // R2 wrap with carry: each element all ones + 0 + 1 -> 0
        for (int w = 0; w < 4; w++)
            run_op({128{1'b1}}, '0, 16'hFFFF, rnd128(), 3'(w), 1'b0, 5'd16,
                   "R2 R3 wrap per width");
        // R1 carry-out of top bit discarded: 0x80+0x80+1 per byte
        run_op({16{8'h80}}, {16{8'h80}}, 16'hFFFF, '0, 3'd0, 1'b0, 5'd16,
               "R1 carry discarded");
        // R4 only low mask bits consulted at 64-bit width
        run_op(rnd128(), rnd128(), 16'hFFFC, rnd128(), 3'd3, 1'b0, 5'd16,
               "R4 upper mask ignored");
        run_op(rnd128(), rnd128(), 16'hFF01, rnd128(), 3'd2, 1'b0, 5'd16,
               "R4 mask bit per element");
        // R5 mask zero still writes body
        run_op({128{1'b1}}, 128'd0, 16'h0000, 128'd0, 3'd1, 1'b0, 5'd8,
               "R5 mask zero writes");
        // R6 tail handling and over-length vl
        run_op(rnd128(), rnd128(), 16'h5A5A, rnd128(), 3'd0, 1'b0, 5'd5,
               "R6 partial vl");
        run_op(rnd128(), rnd128(), 16'h0003, rnd128(), 3'd3, 1'b0, 5'd9,
               "R6 vl beyond count");
        // R7
        run_op(rnd128(), rnd128(), 16'hFFFF, rnd128(), 3'd1, 1'b0, 5'd0,
               "R7 vl zero");
        // R8
        run_op(rnd128(), rnd128(), 16'hFFFF, rnd128(), 3'd0, 1'b1, 5'd16,
               "R8 vm reserved");
        // R9
        run_op(rnd128(), rnd128(), 16'hFFFF, rnd128(), 3'd5, 1'b0, 5'd16,
               "R9 bad width");

        // R10 hold with inputs changing and no valid
        begin
            logic [127:0] held;
            logic hill;
            held = result; hill = illegal;
            @(negedge clk);
            src1 = rnd128(); vm_bit = 1'b1; sew_sel = 3'd7;
            @(negedge clk);
            check(out_valid === 1'b0 && result === held && illegal === hill,
                  "R10 hold", {illegal, result}, {hill, held});
        end

        // R1 R3 R6 random mix
        for (int k = 0; k < 400; k++) begin
            logic [2:0] sel;
            logic [127:0] a;
            sel = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
            a = ($urandom % 4 == 0) ? {128{1'b1}} : rnd128();
            run_op(a, rnd128(), 16'($urandom), rnd128(), sel,
                   ($urandom % 10 == 0), 5'($urandom % 20), "R1 random");
        end

        // R10 no valid after idle
        @(negedge clk);
        check(out_valid === 1'b0, "R10 idle", {128'd0, out_valid}, '0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule